// File: doc/BRIEF.md
# Per-lane DDR deserializer with word alignment and delay-tap tracking

This block receives a bank of serial lanes, each clocked on both edges of a fast I/O clock, and turns every lane into a group of six parallel bits per cycle of a slow clock. The slow clock runs at one third of the fast clock, and the two clocks are phase-aligned. Each slow cycle the block presents six words. Word j holds the j-th bit of every lane's frame, and lane l sits at bit l of every word.

Each lane has its own frame alignment. While a lane's slip request bit is high, the six-bit window for that lane moves one bit position per slow cycle. After six moves the window is back at its starting alignment. Each lane also has a delay-tap counter. It records how many taps of input delay have been requested for that lane: one tap for each slow cycle in which the lane's increment bit is high. The counter stops at its maximum value. The counter models only the requested setting and drives no analog delay element. Reset is synchronous and active-low, and it is sampled in each clock domain.

Top module: `ddr_deser_bank`

## Requirements
- R1: With `rst_n` low at a rising slow-clock edge, every sample word and every tap field reads zero after that edge. Every lane's slip position also returns to zero, so the first frames captured after reset follow the R2 timing. The slip and increment masks have no effect while reset is low.
- R2: Number the fast-clock edges e = 0, 1, 2 and so on. Even e is a rising edge, and edge 0 coincides with slow rising edge 0. With a lane's slip position at zero, the words presented after slow rising edge m carry, in sample word j (j = 0..5), the bit the lane held at fast edge 6m-8+j. Sample 0 is therefore the earliest bit, and bits from rising and falling edges alternate.
- R3: Bit l of every sample word (`samples_o[16*j + l]` for word j) comes only from lane l.
- R4: With slip position s, sample word j of a lane carries the bit from fast edge 6m-8+j-s. Each slow edge at which the lane's `slip_mask` bit is high adds one to s, and the new value applies from the next slow edge on.
- R5: The slip position counts modulo 6. Six slips bring a lane back to its original alignment.
- R6: A lane whose `slip_mask` bit is low at a slow edge keeps its slip position. A lane whose `tap_inc_mask` bit is low keeps its tap count. Neither is affected by the mask bits of other lanes.
- R7: Each slow edge at which a lane's `tap_inc_mask` bit is high adds one to that lane's tap count. Lane l's count appears at `taps_o[6*l+5 : 6*l]`.
- R8: The tap count saturates at 63. Further increment requests leave it at 63, and it never wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast I/O clock; data is captured on both edges |
| clk_slow | input | 1 | Slow clock at one third of `clk_fast`, with rising edges aligned to `clk_fast` rising edges |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both domains |
| lane_din | input | LANES (16) | Serial input bit of each lane |
| slip_mask | input | LANES (16) | Per-lane request to move the frame window, sampled on `clk_slow` |
| tap_inc_mask | input | LANES (16) | Per-lane request for one more delay tap, sampled on `clk_slow` |
| samples_o | output | 6*LANES (96) | Six sample words; word j occupies bits [16j+15:16j] |
| taps_o | output | LANES*6 (96) | Per-lane requested tap count; lane l occupies bits [6l+5:6l] |

## Verification
The bench builds the block with four lanes and the default three DDR pairs and 6-bit tap counters. With four lanes, every one of the sixteen slip-mask patterns can be applied, repeatedly, so each lane passes through all six slip positions and wraps several times while its neighbours hold or move independently. The same small configuration lets one lane be driven past 63 increment requests in a short run, which exposes saturation. The expected words come from an arithmetic bit pattern per lane and edge index, indexed by the bench's own slip model.

// File: rtl/ddr_deser_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the DDR deserializer bank.
package ddr_deser_pkg;

    // Increment a position counter that wraps back to zero at `limit`.
    function automatic int wrap_inc(input int value, input int limit);
        return (value >= limit - 1) ? 0 : value + 1;
    endfunction

endpackage

// File: rtl/ddr_lane_capture.sv
`timescale 1ns/1ps
// Captures one serial lane on both edges of the fast clock. The captured bits
// are kept in a short history shift register, with the oldest bit at the top.
// Assumes the lane input is stable around both fast-clock edges. The history
// is updated on rising edges only, two bits at a time (rise bit, then fall bit).
module ddr_lane_capture #(
    parameter int HIST_W = 11
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              din_i,
    output logic [HIST_W-1:0] hist_o
);

    logic              rise_q;
    logic              fall_q;
    logic [HIST_W-1:0] hist_q;

    // Rising-edge capture flop.
    always_ff @(posedge clk_fast) begin
        rise_q <= din_i;
    end

    // Falling-edge capture flop.
    always_ff @(negedge clk_fast) begin
        fall_q <= din_i;
    end

    // Shift the last rise/fall pair into the history, oldest bit first.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[HIST_W-3:0], rise_q, fall_q};
        end
    end

    assign hist_o = hist_q;

    // R2: the rise bit lands in the history two rising edges after it was on the pin
    a_r2_capture_order: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $past(rst_n) |-> hist_q[1] == $past(din_i, 2));

endmodule

// File: rtl/lane_slip_align.sv
`timescale 1ns/1ps
// Selects one lane's frame from the captured history in the slow-clock domain
// and registers it. The slip position picks how far back the window starts;
// each requested slip moves it one bit and wraps after RATIO positions.
// Assumes clk_slow rising edges coincide with every third clk_fast rising edge.
module lane_slip_align #(
    parameter int RATIO  = 6,
    parameter int HIST_W = 2 * RATIO - 1,
    parameter int SLIP_W = $clog2(RATIO)
) (
    input  logic              clk_slow,
    input  logic              rst_n,
    input  logic              slip_req,
    input  logic [HIST_W-1:0] hist_i,
    output logic [RATIO-1:0]  bits_o
);

    logic [SLIP_W-1:0] slip_q;
    logic [RATIO-1:0]  window;
    logic [RATIO-1:0]  bits_q;

    // Per-lane slip position, advanced once per slow cycle on request.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            slip_q <= '0;
        end else if (slip_req) begin
            slip_q <= SLIP_W'(ddr_deser_pkg::wrap_inc(int'(slip_q), RATIO));
        end
    end

    // Window select: sample j takes the history bit RATIO-1+slip-j.
    always_comb begin
        for (int j = 0; j < RATIO; j++) begin
            window[j] = hist_i[RATIO - 1 + int'(slip_q) - j];
        end
    end

    // Register the aligned frame.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= window;
        end
    end

    assign bits_o = bits_q;

    // R5: the slip position stays inside 0..RATIO-1
    a_r5_slip_range: assert property (@(posedge clk_slow) disable iff (!rst_n)
        int'(slip_q) < RATIO);

    // R5: a slip from the last position wraps to zero
    a_r5_slip_wrap: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (slip_req && int'(slip_q) == RATIO - 1) |=> slip_q == '0);

    // R4: a slip below the last position steps by one
    a_r4_slip_step: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (slip_req && int'(slip_q) != RATIO - 1) |=> slip_q == $past(slip_q) + 1'b1);

    // R6: no request, no movement
    a_r6_slip_hold: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !slip_req |=> $stable(slip_q));

    // R1: reset returns the slip position and the frame to zero
    a_r1_slip_clear: assert property (@(posedge clk_slow)
        !rst_n |=> (slip_q == '0 && bits_o == '0));

endmodule

// File: rtl/delay_tap_counter.sv
`timescale 1ns/1ps
// Counts requested input-delay taps for one lane in the slow-clock domain.
// Saturates at its all-ones value. Models the requested setting only.
module delay_tap_counter #(
    parameter int TAP_W = 6
) (
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic             inc_req,
    output logic [TAP_W-1:0] tap_o
);

    localparam logic [TAP_W-1:0] TAP_MAX = '1;

    logic [TAP_W-1:0] tap_q;

    // Saturating tap counter.
    always_ff @(posedge clk_slow) begin
        if (!rst_n) begin
            tap_q <= '0;
        end else if (inc_req && tap_q != TAP_MAX) begin
            tap_q <= tap_q + 1'b1;
        end
    end

    assign tap_o = tap_q;

    // R7: a request below the maximum adds exactly one tap
    a_r7_tap_step: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (inc_req && tap_q != TAP_MAX) |=> tap_q == $past(tap_q) + 1'b1);

    // R8: once at the maximum the count stays there
    a_r8_tap_saturate: assert property (@(posedge clk_slow) disable iff (!rst_n)
        tap_q == TAP_MAX |=> tap_q == TAP_MAX);

    // R6: no request leaves the count unchanged
    a_r6_tap_hold: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !inc_req |=> $stable(tap_q));

    // R1: reset clears the count
    a_r1_tap_clear: assert property (@(posedge clk_slow)
        !rst_n |=> tap_q == '0);

endmodule

// File: rtl/ddr_deser_bank.sv
`timescale 1ns/1ps
// Bank of DDR serial-to-parallel lanes. Each lane is captured on both fast
// edges, aligned by its own slip position, and registered in the slow domain.
// The slow-domain frames are then transposed into RATIO sample words, with
// lane l at bit l of every word. Each lane also carries a saturating
// requested-delay-tap counter.
// Assumes clk_slow = clk_fast / PAIRS with rising edges aligned.
module ddr_deser_bank #(
    parameter int LANES = 16,
    parameter int PAIRS = 3,
    parameter int TAP_W = 6
) (
    input  logic                     clk_fast,
    input  logic                     clk_slow,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         lane_din,
    input  logic [LANES-1:0]         slip_mask,
    input  logic [LANES-1:0]         tap_inc_mask,
    output logic [2*PAIRS*LANES-1:0] samples_o,
    output logic [LANES*TAP_W-1:0]   taps_o
);

    localparam int RATIO  = 2 * PAIRS;
    localparam int HIST_W = 2 * RATIO - 1;
    localparam int SLIP_W = $clog2(RATIO);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [HIST_W-1:0] hist;
        logic [RATIO-1:0]  frame;

        ddr_lane_capture #(
            .HIST_W (HIST_W)
        ) u_cap (
            .clk_fast (clk_fast),
            .rst_n    (rst_n),
            .din_i    (lane_din[l]),
            .hist_o   (hist)
        );

        lane_slip_align #(
            .RATIO  (RATIO),
            .HIST_W (HIST_W),
            .SLIP_W (SLIP_W)
        ) u_align (
            .clk_slow (clk_slow),
            .rst_n    (rst_n),
            .slip_req (slip_mask[l]),
            .hist_i   (hist),
            .bits_o   (frame)
        );

        delay_tap_counter #(
            .TAP_W (TAP_W)
        ) u_tap (
            .clk_slow (clk_slow),
            .rst_n    (rst_n),
            .inc_req  (tap_inc_mask[l]),
            .tap_o    (taps_o[l*TAP_W +: TAP_W])
        );

        // Transpose: frame bit j of lane l goes to word j, bit l.
        for (genvar j = 0; j < RATIO; j++) begin : g_word
            assign samples_o[j*LANES + l] = frame[j];
        end
    end

endmodule

// File: tb/tb_ddr_deser_bank.sv
`timescale 1ns/1ps
module tb_ddr_deser_bank;

    localparam int L    = 4;
    localparam int R    = 6;
    localparam int TW   = 6;
    localparam int TMAX = 63;

    logic clk_f = 1'b0;
    logic clk_s = 1'b0;
    logic rst_n = 1'b0;
    logic [L-1:0]   din       = '0;
    logic [L-1:0]   slip_mask = '0;
    logic [L-1:0]   inc_mask  = '0;
    logic [R*L-1:0] samples;
    logic [L*TW-1:0] taps;

    int errors = 0;
    int checks = 0;
    int slip_m [L];
    int tap_m  [L];

    ddr_deser_bank #(.LANES(L), .PAIRS(3), .TAP_W(TW)) dut (
        .clk_fast     (clk_f),
        .clk_slow     (clk_s),
        .rst_n        (rst_n),
        .lane_din     (din),
        .slip_mask    (slip_mask),
        .tap_inc_mask (inc_mask),
        .samples_o    (samples),
        .taps_o       (taps)
    );

    // 50 MHz fast clock: rising edges at 10, 30, 50 ns ...
    initial forever #10 clk_f = ~clk_f;
    // Slow clock at one third, rising edges at 10, 70, 130 ns ...
    initial begin
        #10 clk_s = 1'b1;
        forever #30 clk_s = ~clk_s;
    end

    // Arithmetic bit pattern per lane and fast-edge index.
    function automatic logic sbit(input int lane, input int e);
        int unsigned h;
        if (e < 0) return 1'b0;
        h = int'(e) * int'(e) * 7 + int'(e) * (lane + 1) * 13 + lane * 5 + 3;
        return ^h[6:2];
    endfunction

    // Serial driver: fast edge e is at 10+10e ns; its bit is set 5 ns before.
    initial begin
        int e;
        e = 0;
        #5;
        forever begin
            for (int l = 0; l < L; l++) din[l] = sbit(l, e);
            e++;
            #10;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(60 * 3000);
        errors++;
        checks++;
        $display("FAIL watchdog R1-R8 actual=timeout expected=completion");
        finish_run();
    end

    // One slow cycle: apply inputs, wait for the edge, model it, check 5 ns later.
    task automatic cycle(input logic [L-1:0] bs, input logic [L-1:0] di,
                         input logic rst_v, input bit chk,
                         input string tag_s, input string tag_t);
        logic [R*L-1:0]  exp_s;
        logic [L*TW-1:0] exp_t;
        int m;
        slip_mask = bs;
        inc_mask  = di;
        rst_n     = rst_v;
        @(posedge clk_s);
        m = int'(($time - 10) / 60);
        for (int l = 0; l < L; l++) begin
            for (int j = 0; j < R; j++) begin
                exp_s[j*L + l] = rst_v ? sbit(l, 6*m - 8 + j - slip_m[l]) : 1'b0;
            end
        end
        for (int l = 0; l < L; l++) begin
            if (!rst_v) begin
                slip_m[l] = 0;
                tap_m[l]  = 0;
            end else begin
                if (bs[l]) slip_m[l] = (slip_m[l] + 1) % R;
                if (di[l] && tap_m[l] < TMAX) tap_m[l] = tap_m[l] + 1;
            end
            exp_t[l*TW +: TW] = TW'(tap_m[l]);
        end
        #5;
        if (chk) begin
            checks++;
            if (samples !== exp_s) begin
                errors++;
                $display("FAIL %s samples actual=%h expected=%h", tag_s, samples, exp_s);
            end
            checks++;
            if (taps !== exp_t) begin
                errors++;
                $display("FAIL %s taps actual=%h expected=%h", tag_t, taps, exp_t);
            end
        end
    endtask

    initial begin
        for (int l = 0; l < L; l++) begin
            slip_m[l] = 0;
            tap_m[l]  = 0;
        end
        // R1: reset state, with masks high that must be ignored.
        for (int k = 0; k < 3; k++) cycle('1, '1, 1'b0, 1'b1, "R1", "R1");
        for (int k = 0; k < 3; k++) cycle('0, '0, 1'b1, 1'b0, "", "");
        // R2 R3: plain capture, no slips.
        for (int k = 0; k < 8; k++) cycle('0, '0, 1'b1, 1'b1, "R2 R3", "R6");
        // R4 R5 R6 R7: every slip pattern, each lane wrapping several times.
        for (int rep = 0; rep < 3; rep++) begin
            for (int mk = 0; mk < 16; mk++) begin
                cycle(L'(mk), L'(15 - mk), 1'b1, 1'b1, "R4 R5 R6", "R7 R6");
            end
        end
        for (int k = 0; k < 4; k++) cycle('0, '0, 1'b1, 1'b1, "R4 R5", "R7");
        // R8: drive lane 0 well past the maximum count.
        for (int k = 0; k < 45; k++) cycle(4'b0010, 4'b0001, 1'b1, 1'b1, "R4 R6", "R8");
        // R1: reset in mid-run clears slips and taps.
        for (int k = 0; k < 2; k++) cycle('1, '1, 1'b0, 1'b1, "R1", "R1");
        for (int k = 0; k < 3; k++) cycle('0, '0, 1'b1, 1'b0, "", "");
        for (int k = 0; k < 6; k++) cycle('0, '0, 1'b1, 1'b1, "R1 R2", "R1");
        finish_run();
    end

endmodule